// File: doc/BRIEF.md
# ECC Event Address Capture

This block sits beside a flash read path that has two read ports: an instruction-fetch port and a data port. Each port reports, once per cycle, whether the word it just read needed a single-bit correction or held an uncorrectable error (two or more bad bits), along with the 19-bit flash address of that word. Software picks which event types may raise an interrupt through two enable inputs. The block then records the address of the first enabled event in a 32-bit read-only register. Separate sticky status bits show which event types have been seen. An interrupt request is raised from these bits, and a bus-fault output is raised for uncorrectable errors.

When several enabled events occur in the same cycle, the block picks one by a two-level priority. An uncorrectable error wins over a correction. Between events of the same type, the instruction port wins over the data port. Once an address is held, it is frozen while any status bit is set. A single-cycle clear pulse drops both status bits. If a new enabled event arrives in the same cycle as the clear, that event is recorded and its status bit stays set. The address register itself is cleared only by reset.

The status keeper is a four-state machine. Its states are ST_ARMED (no status, capture allowed), ST_CORR (correction seen), ST_ERR (error seen) and ST_BOTH (both seen). Its transitions are:
- ARM_TO_SEEN: leave ST_ARMED on an enabled event.
- SEEN_ADD: move from ST_CORR or ST_ERR to ST_BOTH when an event of the other type arrives.
- CLR_TO_ARMED: return to ST_ARMED on a clear with no enabled event.
- CLR_REARM: on a clear that coincides with enabled events, go straight to the state those events select.

Top module: `ecc_event_capture`

## Requirements
- R1: After reset the address register reads 0x00000000, both status bits are 0, and the interrupt and bus-fault outputs are 0.
- R2: An event whose type is not enabled (`en_err`=0 for errors, `en_corr`=0 for corrections) neither updates the address nor sets a status bit, even if it occurs in the same cycle as an enabled event of the other type.
- R3: The first enabled event while both status bits are 0 is captured. While any status bit is set and no clear is applied, later events do not change the address.
- R4: A clear pulse in the same cycle as an enabled event stores that event's address. The status afterwards holds only the bits of the event types present in that cycle.
- R5: When an enabled error and an enabled correction occur in the same cycle, on either port, the error's address is stored.
- R6: When both ports report enabled events of the same type in the same cycle, the instruction-port address is stored.
- R7: A clear does not change the address register. The next enabled event after the clear is captured.
- R8: The error and correction status bits are independent and sticky: an event of the other type sets its own bit without moving the address. A clear with no enabled event drops both bits.
- R9: `irq` = (`err_stat` & `en_err`) | (`corr_stat` & `en_corr`), and `bus_fault` = `err_stat` & `en_err`. Both follow the enables in the same cycle.
- R10: The captured address occupies bits [18:0] of `addr_reg`. Bits [31:19] read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| if_corr | input | 1 | Instruction port: single-bit correction this cycle |
| if_err | input | 1 | Instruction port: uncorrectable error this cycle |
| if_addr | input | 19 | Instruction port read address |
| dp_corr | input | 1 | Data port: single-bit correction this cycle |
| dp_err | input | 1 | Data port: uncorrectable error this cycle |
| dp_addr | input | 19 | Data port read address |
| en_corr | input | 1 | Interrupt enable for corrections |
| en_err | input | 1 | Interrupt enable for uncorrectable errors |
| stat_clr | input | 1 | Single-cycle pulse clearing both status bits |
| err_stat | output | 1 | Sticky uncorrectable-error status |
| corr_stat | output | 1 | Sticky correction status |
| addr_reg | output | 32 | Captured address register, bits [18:0] |
| irq | output | 1 | Interrupt request |
| bus_fault | output | 1 | Bus fault for enabled uncorrectable errors |

## Verification
An event or clear is sampled at one rising edge. The address register and status bits show its effect right after that edge, which is one cycle of latency. `irq` and `bus_fault` are combinational from the registered status and the live enables. After a status change they are due in the same cycle as the status. After an enable change they are due with no clock at all. The bench changes inputs on falling edges, holds them across exactly one rising edge, and checks at the following falling edge. Enable-only checks are taken a short delay after the change, with no clock edge in between.

// File: rtl/ecc_cap_pkg.sv
package ecc_cap_pkg;

    localparam int unsigned ADDR_W  = 19;
    localparam int unsigned REG_W   = 32;
    localparam int unsigned NPORTS  = 2;

    // port index 0 has the highest priority (instruction fetch)
    localparam int unsigned PORT_IF = 0;
    localparam int unsigned PORT_DP = 1;

    typedef enum logic [1:0] {
        ST_ARMED = 2'b00,
        ST_CORR  = 2'b01,
        ST_ERR   = 2'b10,
        ST_BOTH  = 2'b11
    } stat_state_t;

    typedef struct packed {
        logic              corr;
        logic              err;
        logic [ADDR_W-1:0] addr;
    } port_evt_t;

endpackage

// File: rtl/ecc_evt_arbiter.sv
module ecc_evt_arbiter
    import ecc_cap_pkg::*;
#(
    parameter int unsigned P_AW    = ADDR_W,
    parameter int unsigned P_PORTS = NPORTS
) (
    input  logic [P_PORTS-1:0]       evt_corr,
    input  logic [P_PORTS-1:0]       evt_err,
    input  logic [P_PORTS-1:0][P_AW-1:0] evt_addr,
    input  logic                     en_corr,
    input  logic                     en_err,
    output logic                     qual_err,
    output logic                     qual_corr,
    output logic                     win_valid,
    output logic [P_AW-1:0]          win_addr
);

    logic [P_PORTS-1:0] q_err;
    logic [P_PORTS-1:0] q_corr;
    logic [P_AW-1:0]    err_addr;
    logic [P_AW-1:0]    corr_addr;

    genvar g;
    generate
        for (g = 0; g < P_PORTS; g++) begin : g_qual
            assign q_err[g]  = evt_err[g]  & en_err;
            assign q_corr[g] = evt_corr[g] & en_corr;
        end
    endgenerate

    assign qual_err  = |q_err;
    assign qual_corr = |q_corr;

    // scan from the lowest-priority port up so the lowest index wins
    always_comb begin
        err_addr  = '0;
        corr_addr = '0;
        for (int i = P_PORTS - 1; i >= 0; i--) begin
            if (q_err[i])  err_addr  = evt_addr[i];
            if (q_corr[i]) corr_addr = evt_addr[i];
        end
    end

    // errors take precedence over corrections
    always_comb begin
        win_valid = qual_err | qual_corr;
        win_addr  = qual_err ? err_addr : corr_addr;
    end

endmodule

// File: rtl/ecc_status_fsm.sv
module ecc_status_fsm
    import ecc_cap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic qual_err,
    input  logic qual_corr,
    input  logic win_valid,
    input  logic stat_clr,
    output logic err_stat,
    output logic corr_stat,
    output logic capture
);

    stat_state_t state_q, base, state_d;
    logic        base_err, base_corr;

    always_comb begin
        base = stat_clr ? ST_ARMED : state_q;
        unique case (base)
            ST_ARMED: begin base_err = 1'b0; base_corr = 1'b0; end
            ST_CORR:  begin base_err = 1'b0; base_corr = 1'b1; end
            ST_ERR:   begin base_err = 1'b1; base_corr = 1'b0; end
            ST_BOTH:  begin base_err = 1'b1; base_corr = 1'b1; end
            default:  begin base_err = 1'b0; base_corr = 1'b0; end
        endcase
        unique case ({base_err | qual_err, base_corr | qual_corr})
            2'b00:   state_d = ST_ARMED;
            2'b01:   state_d = ST_CORR;
            2'b10:   state_d = ST_ERR;
            2'b11:   state_d = ST_BOTH;
            default: state_d = ST_ARMED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_ARMED;
        else        state_q <= state_d;
    end

    always_comb begin
        err_stat  = (state_q == ST_ERR)  || (state_q == ST_BOTH);
        corr_stat = (state_q == ST_CORR) || (state_q == ST_BOTH);
        capture   = win_valid && (base == ST_ARMED);
    end

    AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        stat_clr && !win_valid |=> !err_stat && !corr_stat); // R8
    AST_CLR_WITH_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        stat_clr && win_valid |=> err_stat || corr_stat); // R4
    AST_NO_QUAL_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        !err_stat && !corr_stat && !win_valid |=> !err_stat && !corr_stat); // R2
    AST_STICKY_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        err_stat && !stat_clr |=> err_stat); // R8

endmodule

// File: rtl/ecc_addr_reg.sv
module ecc_addr_reg
    import ecc_cap_pkg::*;
#(
    parameter int unsigned P_AW = ADDR_W,
    parameter int unsigned P_RW = REG_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cap_en,
    input  logic [P_AW-1:0] cap_addr,
    output logic [P_RW-1:0] reg_word
);

    localparam int unsigned PAD_W = P_RW - P_AW;

    logic [P_AW-1:0] addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      addr_q <= '0;
        else if (cap_en) addr_q <= cap_addr;
    end

    assign reg_word = {{PAD_W{1'b0}}, addr_q};

endmodule

// File: rtl/ecc_event_capture.sv
module ecc_event_capture
    import ecc_cap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              if_corr,
    input  logic              if_err,
    input  logic [ADDR_W-1:0] if_addr,
    input  logic              dp_corr,
    input  logic              dp_err,
    input  logic [ADDR_W-1:0] dp_addr,
    input  logic              en_corr,
    input  logic              en_err,
    input  logic              stat_clr,
    output logic              err_stat,
    output logic              corr_stat,
    output logic [REG_W-1:0]  addr_reg,
    output logic              irq,
    output logic              bus_fault
);

    logic [NPORTS-1:0]             p_corr, p_err;
    logic [NPORTS-1:0][ADDR_W-1:0] p_addr;
    logic                          qual_err, qual_corr, win_valid, capture;
    logic [ADDR_W-1:0]             win_addr;

    always_comb begin
        p_corr          = '0;
        p_err           = '0;
        p_addr          = '0;
        p_corr[PORT_IF] = if_corr;
        p_err[PORT_IF]  = if_err;
        p_addr[PORT_IF] = if_addr;
        p_corr[PORT_DP] = dp_corr;
        p_err[PORT_DP]  = dp_err;
        p_addr[PORT_DP] = dp_addr;
    end

    ecc_evt_arbiter #(.P_AW(ADDR_W), .P_PORTS(NPORTS)) u_arb (
        .evt_corr (p_corr),
        .evt_err  (p_err),
        .evt_addr (p_addr),
        .en_corr  (en_corr),
        .en_err   (en_err),
        .qual_err (qual_err),
        .qual_corr(qual_corr),
        .win_valid(win_valid),
        .win_addr (win_addr)
    );

    ecc_status_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .qual_err (qual_err),
        .qual_corr(qual_corr),
        .win_valid(win_valid),
        .stat_clr (stat_clr),
        .err_stat (err_stat),
        .corr_stat(corr_stat),
        .capture  (capture)
    );

    ecc_addr_reg #(.P_AW(ADDR_W), .P_RW(REG_W)) u_areg (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_en  (capture),
        .cap_addr(win_addr),
        .reg_word(addr_reg)
    );

    assign bus_fault = err_stat & en_err;
    assign irq       = bus_fault | (corr_stat & en_corr);

    AST_HOLD_WHILE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (err_stat || corr_stat) && !stat_clr |=> $stable(addr_reg)); // R3
    AST_IF_ERR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        !err_stat && !corr_stat && en_err && if_err
        |=> addr_reg[ADDR_W-1:0] == $past(if_addr)); // R6
    AST_ERR_OVER_CORR: assert property (@(posedge clk) disable iff (!rst_n)
        !err_stat && !corr_stat && en_err && dp_err && !if_err
        |=> addr_reg[ADDR_W-1:0] == $past(dp_addr)); // R5
    AST_FAULT_IMPLIES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        bus_fault |-> irq); // R9
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        addr_reg[REG_W-1:ADDR_W] == '0); // R10

endmodule

// File: tb/test_ecc_event_capture.sv
`timescale 1ns/1ps
module test_ecc_event_capture;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        if_corr = 0, if_err = 0, dp_corr = 0, dp_err = 0;
    logic [18:0] if_addr = '0, dp_addr = '0;
    logic        en_corr = 0, en_err = 0, stat_clr = 0;
    logic        err_stat, corr_stat, irq, bus_fault;
    logic [31:0] addr_reg;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    ecc_event_capture i_ecc_event_capture (
        .clk(clk), .rst_n(rst_n),
        .if_corr(if_corr), .if_err(if_err), .if_addr(if_addr),
        .dp_corr(dp_corr), .dp_err(dp_err), .dp_addr(dp_addr),
        .en_corr(en_corr), .en_err(en_err), .stat_clr(stat_clr),
        .err_stat(err_stat), .corr_stat(corr_stat), .addr_reg(addr_reg),
        .irq(irq), .bus_fault(bus_fault)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // drive one cycle of stimulus across a single rising edge, check at next falling edge
    task automatic step(input logic ic, input logic ie, input logic [18:0] ia,
                        input logic dc, input logic de, input logic [18:0] da,
                        input logic clr);
        if_corr = ic; if_err = ie; if_addr = ia;
        dp_corr = dc; dp_err = de; dp_addr = da;
        stat_clr = clr;
        @(negedge clk);
        if_corr = 0; if_err = 0; dp_corr = 0; dp_err = 0; stat_clr = 0;
    endtask

    task automatic clear_all();
        step(0, 0, '0, 0, 0, '0, 1);
    endtask

    task automatic t_reset();
        chk("R1 addr", addr_reg, 32'h0);
        chk("R1 stat", {30'b0, err_stat, corr_stat}, 32'h0);
        chk("R1 irq", {30'b0, irq, bus_fault}, 32'h0);
    endtask

    task automatic t_disabled();
        en_err = 0; en_corr = 0;
        step(0, 1, 19'h00005, 1, 0, 19'h00006, 0);
        chk("R2 both disabled addr", addr_reg, 32'h0);
        chk("R2 both disabled stat", {30'b0, err_stat, corr_stat}, 32'h0);
        en_corr = 1;
        step(0, 1, 19'h00015, 0, 0, '0, 0);
        chk("R2 err disabled addr", addr_reg, 32'h0);
        chk("R2 err disabled stat", {30'b0, err_stat, corr_stat}, 32'h0);
        // disabled error on IF alongside enabled correction on DP: DP wins
        step(0, 1, 19'h00025, 1, 0, 19'h00026, 0);
        chk("R2 mixed addr", addr_reg, 32'h26);
        chk("R2 mixed stat", {30'b0, err_stat, corr_stat}, 32'h1);
        en_err = 1;
        clear_all();
    endtask

    task automatic t_first_sticky();
        en_err = 1; en_corr = 1;
        step(0, 0, '0, 1, 0, 19'h00111, 0);
        chk("R3 first capture", addr_reg, 32'h111);
        chk("R3 corr stat", {30'b0, err_stat, corr_stat}, 32'h1);
        step(1, 0, 19'h00222, 0, 0, '0, 0);
        chk("R3 no overwrite", addr_reg, 32'h111);
        step(0, 1, 19'h00333, 0, 0, '0, 0);
        chk("R8 err added addr", addr_reg, 32'h111);
        chk("R8 both stat", {30'b0, err_stat, corr_stat}, 32'h3);
        chk("R9 irq fault", {30'b0, irq, bus_fault}, 32'h3);
        clear_all();
        chk("R8 clear stat", {30'b0, err_stat, corr_stat}, 32'h0);
        chk("R7 addr kept", addr_reg, 32'h111);
        chk("R9 irq low", {30'b0, irq, bus_fault}, 32'h0);
        step(1, 0, 19'h00444, 0, 0, '0, 0);
        chk("R7 recapture", addr_reg, 32'h444);
        clear_all();
    endtask

    task automatic t_clr_coincide();
        step(1, 0, 19'h000AA, 0, 0, '0, 0);
        chk("R4 setup", addr_reg, 32'hAA);
        step(0, 0, '0, 0, 1, 19'h000BB, 1);
        chk("R4 addr", addr_reg, 32'hBB);
        chk("R4 stat", {30'b0, err_stat, corr_stat}, 32'h2);
        clear_all();
    endtask

    task automatic t_err_prio();
        step(1, 0, 19'h00010, 0, 1, 19'h00020, 0);
        chk("R5 err over corr", addr_reg, 32'h20);
        chk("R5 stat", {30'b0, err_stat, corr_stat}, 32'h3);
        clear_all();
    endtask

    task automatic t_port_prio();
        step(0, 1, 19'h7FFFF, 0, 1, 19'h00001, 0);
        chk("R6 err port", addr_reg, 32'h0007FFFF);
        chk("R10 upper zero", {13'b0, addr_reg[31:13]}, 32'h3F);
        clear_all();
        step(1, 0, 19'h00030, 1, 0, 19'h00040, 0);
        chk("R6 corr port", addr_reg, 32'h30);
        clear_all();
    endtask

    task automatic t_irq_mask();
        step(0, 1, 19'h00050, 0, 0, '0, 0);
        chk("R9 err set", {30'b0, irq, bus_fault}, 32'h3);
        en_err = 0; #1;
        chk("R9 masked", {30'b0, irq, bus_fault}, 32'h0);
        en_err = 1; #1;
        chk("R9 unmasked", {30'b0, irq, bus_fault}, 32'h3);
        @(negedge clk);
        clear_all();
        step(1, 0, 19'h00060, 0, 0, '0, 0);
        en_corr = 0; #1;
        chk("R9 corr masked", {30'b0, irq, bus_fault}, 32'h0);
        en_corr = 1; #1;
        chk("R9 corr irq", {30'b0, irq, bus_fault}, 32'h2);
        @(negedge clk);
        clear_all();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_first_sticky();
        t_clr_coincide();
        t_err_prio();
        t_port_prio();
        t_irq_mask();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_vec++; n_bad++;
                $display("FAIL watchdog: got 0x0 expected 0x1");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule